// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets a host on a two-wire management bus read and write a small file of 8-bit configuration registers. It watches oversampled copies of the clock line (SCL) and data line (SDA) on the system clock, finds START, repeated START and STOP conditions, and checks the 7-bit slave address in the first byte of each transfer. A write carries the slave address, a register pointer and then any number of data bytes, with the pointer stepping by one after each byte. A read is a combined transfer: the pointer is set by a write, then a repeated START and the address with the read bit make the slave return bytes until the host answers with NACK.

The slave's own address is held in register 0 and can be changed over the bus, so several slaves can share one bus. A chip-select input gates the whole interface: while it is low the slave ignores the bus and never drives SDA. A soft-reset bit in register 1 returns every register except the address register to its default value. SDA is driven in open-drain form: `sda_oe_o` high means the line is pulled low. The interface carries no streaming data, so it has no valid/ready handshake. Every pin is a plain level, and the register contents are presented as a flat vector for the logic around the block.

Top module: `cfgbus_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) begins a transfer and a STOP (SDA rises while SCL is high). Bytes are 8 bits, MSB first, and a matching address byte is acknowledged by pulling SDA low during the ninth clock. Clock pulses after a STOP with no new START get no response.
- R2: An address byte whose upper 7 bits differ from the stored address gets a NACK. The slave then keeps SDA released and acknowledges nothing until the next START.
- R3: In a write (address byte with bit 0 = 0), the second byte sets the register pointer and each later byte is acknowledged, stored at the pointer, and advances the pointer by one. Writes to pointers at or above NUM_REGS are acknowledged and discarded.
- R4: In a combined read (address byte with bit 0 = 1 after a repeated START), the slave drives the byte at the pointer MSB first and advances the pointer. It sends the next byte while the host acknowledges and releases SDA after a host NACK. The 8-bit pointer wraps from 0xFF to 0x00.
- R5: Register 0 holds the slave address in bits 7:1 and reads 0 in bit 0. A write to it changes the address that following transfers must match.
- R6: Writing a byte with bit 0 set to register 1 restores registers 1 to NUM_REGS-1 to their defaults and leaves register 0 unchanged. Bit 0 of register 1 always reads 0.
- R7: While `cs_i` is low the slave never drives SDA and ignores the bus. Lowering `cs_i` in the middle of a transfer aborts it, and the slave waits for a new START.
- R8: When SCL and SDA both stay high for BUS_FREE_CYC consecutive system clocks, the slave drops any transfer in progress and waits for a START.
- R9: After reset `sda_oe_o` is low and the registers hold their defaults: register 0 = 0x58 (address 0x2C), register 1 = 0x00, register i (i ≥ 2) = 0xA0 + i.
- R10: Reads of pointers at or above NUM_REGS return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select; the slave takes part in the bus only while high |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |
| regs_o | output | NUM_REGS*8 | Register contents, register i in bits 8i+7:8i |

## Verification
The bench targets pointer handling at its edges: a burst that must step through consecutive registers, a read that wraps from 0xFF into the address register, and out-of-range pointers. A design that latched the pointer late or failed to wrap would return the wrong bytes. It also rewrites the slave address, then checks that the old address is refused and that a soft reset keeps the new one. A soft reset that cleared register 0 would make the slave unreachable. Aborts get their own tests: chip select dropped mid-transfer, and a bus held idle-high inside a byte. A slave that ignored either would acknowledge a byte it should no longer count. A further test clocks a byte with no START after a STOP, where a slave that stayed armed would wrongly acknowledge.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  localparam logic [7:0] ADDR_REG_DEFAULT = 8'h58;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_REG,
    PH_WDAT,
    PH_RDAT,
    PH_HOLD
  } phase_e;

  function automatic logic [7:0] reg_default(int idx);
    if (idx == 0)      return ADDR_REG_DEFAULT;
    else if (idx == 1) return 8'h00;
    else               return 8'hA0 + 8'(idx);
  endfunction

endpackage

// File: rtl/cfgbus_sync.sv
module cfgbus_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/cfgbus_busfree.sv
module cfgbus_busfree #(
  parameter int FREE_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic timeout_o
);
  localparam int             CW  = $clog2(FREE_CYC + 1);
  localparam logic [CW-1:0]  LIM = CW'(FREE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!(scl_s && sda_s)) cnt <= '0;
    else if (cnt != LIM)        cnt <= cnt + 1'b1;
  end

  assign timeout_o = (cnt == LIM);

  // Timeout may only follow a cycle in which both lines were high
  AST_TIMEOUT_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> $past(scl_s && sda_s)); // R8
endmodule

// File: rtl/cfgbus_regfile.sv
module cfgbus_regfile
  import cfgbus_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_addr,
  output logic [7:0]            rd_data,
  output logic [6:0]            dev_addr,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic soft_rst;
  assign soft_rst = wr_en && (wr_addr == 8'd1) && wr_data[0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] DEF = reg_default(g);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= DEF;
      else if (g != 0 && soft_rst)             q <= DEF;
      else if (wr_en && wr_addr == 8'(g))      q <= (g <= 1) ? {wr_data[7:1], 1'b0} : wr_data;
    end
    assign regs_o[g*8 +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == 8'(i)) rd_data = regs_o[i*8 +: 8];
  end

  assign dev_addr = regs_o[7:1];

  AST_SOFT_RST_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> $stable(regs_o[7:0])); // R6
  AST_SOFT_RST_CLEARS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (regs_o[15:8] == 8'h00)); // R6
  AST_ADDR_BIT0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'd0) |=> !regs_o[0]); // R5
endmodule

// File: rtl/cfgbus_engine.sv
module cfgbus_engine
  import cfgbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_s,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       timeout,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_addr,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_oe_o
);
  phase_e     phase;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] txbyte;
  logic [7:0] ptr;
  logic       rw_bit;
  logic       host_nack;
  logic       scl_q;
  logic       sda_q;
  logic       oe_q;

  logic scl_rise, scl_fall, start_ev, stop_ev, in_xfer;
  logic [2:0] tx_idx;

  assign scl_rise = scl_s && !scl_q;
  assign scl_fall = !scl_s && scl_q;
  assign start_ev = scl_s && scl_q && sda_q && !sda_s;
  assign stop_ev  = scl_s && scl_q && !sda_q && sda_s;
  assign in_xfer  = phase inside {PH_DEV, PH_REG, PH_WDAT, PH_RDAT};
  assign tx_idx   = 3'd7 - bitcnt[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txbyte    <= '0;
      ptr       <= '0;
      rw_bit    <= 1'b0;
      host_nack <= 1'b1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      oe_q      <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      wr_en <= 1'b0;
      if (!cs_s) begin
        phase  <= PH_IDLE;
        bitcnt <= '0;
        oe_q   <= 1'b0;
      end else if (start_ev) begin
        phase  <= PH_DEV;
        bitcnt <= '0;
        oe_q   <= 1'b0;
      end else if (stop_ev || timeout) begin
        phase <= PH_IDLE;
        oe_q  <= 1'b0;
      end else if (in_xfer) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_s};
          else               host_nack <= sda_s;
          bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (phase)
              PH_DEV: begin
                if (shreg[7:1] == dev_addr) begin
                  oe_q   <= 1'b1;
                  rw_bit <= shreg[0];
                end else begin
                  phase <= PH_HOLD;
                end
              end
              PH_REG: begin
                ptr  <= shreg;
                oe_q <= 1'b1;
              end
              PH_WDAT: begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr + 1'b1;
                oe_q    <= 1'b1;
              end
              default: oe_q <= 1'b0;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            oe_q   <= 1'b0;
            case (phase)
              PH_DEV: begin
                if (rw_bit) begin
                  phase  <= PH_RDAT;
                  txbyte <= rd_data;
                  ptr    <= ptr + 1'b1;
                  oe_q   <= !rd_data[7];
                end else begin
                  phase <= PH_REG;
                end
              end
              PH_REG: phase <= PH_WDAT;
              PH_RDAT: begin
                if (host_nack) begin
                  phase <= PH_HOLD;
                end else begin
                  txbyte <= rd_data;
                  ptr    <= ptr + 1'b1;
                  oe_q   <= !rd_data[7];
                end
              end
              default: ;
            endcase
          end else if (phase == PH_RDAT && bitcnt != 4'd0) begin
            oe_q <= !txbyte[tx_idx];
          end
        end
      end
    end
  end

  assign rd_addr  = ptr;
  assign sda_oe_o = oe_q;

  AST_CS_LOW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !sda_oe_o); // R7
  AST_HOLD_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |-> !sda_oe_o); // R2
  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s) && !$stable(sda_oe_o)) |-> !scl_s); // R1
  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9); // R1
endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
  import cfgbus_pkg::*;
#(
  parameter int NUM_REGS     = 8,
  parameter int BUS_FREE_CYC = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_i,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [2:0] pins_s;
  logic       timeout;
  logic [6:0] dev_addr;
  logic [7:0] rd_data, rd_addr, wr_addr, wr_data;
  logic       wr_en;

  cfgbus_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cs_i, scl_i, sda_i}),
    .q_o   (pins_s)
  );

  cfgbus_busfree #(.FREE_CYC(BUS_FREE_CYC)) u_busfree (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (pins_s[1]),
    .sda_s     (pins_s[0]),
    .timeout_o (timeout)
  );

  cfgbus_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (pins_s[2]),
    .scl_s    (pins_s[1]),
    .sda_s    (pins_s[0]),
    .timeout  (timeout),
    .dev_addr (dev_addr),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sda_oe_o (sda_oe_o)
  );

  cfgbus_regfile #(.NUM_REGS(NUM_REGS)) u_regfile (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .dev_addr (dev_addr),
    .regs_o   (regs_o)
  );
endmodule

// File: tb/cfgbus_slave_tb_top.sv
module cfgbus_slave_tb_top;
  localparam int NR   = 8;
  localparam int FREE = 64;
  localparam int H    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs;
  wire  sda_line = sda_h & ~sda_oe;

  always #10 clk = ~clk;

  cfgbus_slave #(.NUM_REGS(NR), .BUS_FREE_CYC(FREE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // {register, data written, value expected on read-back}
  localparam logic [23:0] VEC [6] = '{
    24'h02_3C_3C, 24'h03_FF_FF, 24'h07_81_81,
    24'h01_F6_F6, 24'h09_55_00, 24'h05_00_00
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; clks(2);
    scl_h = 1'b1; clks(H);
    sda_h = 1'b0; clks(H);
    scl_h = 1'b0; clks(2);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; clks(2);
    scl_h = 1'b1; clks(H);
    sda_h = 1'b1; clks(H);
  endtask

  // sends the top n bits of b, then one acknowledge clock; ack = 0 means ACK
  task automatic send_bits(logic [7:0] b, int n, output logic ack);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; clks(H);
      scl_h = 1'b1; clks(H);
      scl_h = 1'b0; clks(2);
    end
    sda_h = 1'b1; clks(H);
    scl_h = 1'b1; clks(H/2);
    ack = sda_line; clks(H/2);
    scl_h = 1'b0; clks(H);
  endtask

  task automatic wb(logic [7:0] b, output logic ack);
    send_bits(b, 8, ack);
  endtask

  task automatic read_byte(bit host_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clks(H);
      scl_h = 1'b1; clks(H/2);
      b[i] = sda_line; clks(H/2);
      scl_h = 1'b0;
    end
    clks(2);
    sda_h = host_ack ? 1'b0 : 1'b1; clks(H);
    scl_h = 1'b1; clks(H);
    scl_h = 1'b0; clks(2);
    sda_h = 1'b1; clks(H);
  endtask

  task automatic wr_reg(logic [6:0] a, logic [7:0] r, logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    wb({a, 1'b0}, a0); wb(r, a1); wb(d, a2);
    bus_stop();
    ok = !a0 && !a1 && !a2;
  endtask

  task automatic rd_reg(logic [6:0] a, logic [7:0] r, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    wb({a, 1'b0}, a0); wb(r, a1);
    bus_start();
    wb({a, 1'b1}, a2);
    read_byte(1'b0, d);
    bus_stop();
    ok = !a0 && !a1 && !a2;
  endtask

  function automatic logic [NR*8-1:0] defaults(logic [7:0] r0);
    logic [NR*8-1:0] v;
    v[7:0] = r0;
    v[15:8] = 8'h00;
    for (int i = 2; i < NR; i++) v[i*8 +: 8] = 8'hA0 + 8'(i);
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual running expected finished");
      report();
      $finish;
    end
  end

  initial begin
    logic ok, ack, a1, a2, a3;
    logic [7:0] d, d1, d2, d3;

    clks(4);
    chk("R9 sda_oe in reset", {63'd0, sda_oe}, 64'd0);
    chk("R9 register defaults", regs, defaults(8'h58));
    rst_n = 1'b1; cs = 1'b1; clks(20);

    // table walk: write, then combined read-back (R3, R4, R10)
    for (int k = 0; k < 6; k++) begin
      wr_reg(7'h2C, VEC[k][23:16], VEC[k][15:8], ok);
      chk("R3 write acknowledged", {63'd0, ok}, 64'd1);
      rd_reg(7'h2C, VEC[k][23:16], d, ok);
      chk("R4 read acknowledged", {63'd0, ok}, 64'd1);
      chk("R4/R10 read-back value", {56'd0, d}, {56'd0, VEC[k][7:0]});
    end

    // burst write with auto-increment (R3)
    bus_start();
    wb(8'h58, a1); wb(8'h02, a2); wb(8'h11, a3);
    chk("R1 address ack", {63'd0, a1}, 64'd0);
    wb(8'h22, a1); wb(8'h33, a2); bus_stop();
    chk("R3 burst data ack", {62'd0, a1, a2}, 64'd0);
    chk("R3 burst stored", {40'd0, regs[39:16]}, 64'h33_22_11);

    // burst read with host ACKs (R4)
    bus_start(); wb(8'h58, a1); wb(8'h02, a2);
    bus_start(); wb(8'h59, a3);
    read_byte(1'b1, d1); read_byte(1'b1, d2); read_byte(1'b0, d3);
    bus_stop();
    chk("R4 burst read", {40'd0, d1, d2, d3}, 64'h11_22_33);
    chk("R4 host NACK releases bus", {63'd0, sda_oe}, 64'd0);

    // pointer wrap 0xFF -> 0x00 (R4, R10)
    bus_start(); wb(8'h58, a1); wb(8'hFF, a2);
    bus_start(); wb(8'h59, a3);
    read_byte(1'b1, d1); read_byte(1'b0, d2);
    bus_stop();
    chk("R4 wrap read", {48'd0, d1, d2}, 64'h00_58);

    // no START after STOP: no response (R1)
    scl_h = 1'b0; clks(H);
    wb(8'h58, ack);
    chk("R1 no ack without START", {63'd0, ack}, 64'd1);
    scl_h = 1'b1; clks(H);

    // wrong address (R2)
    bus_start(); wb(8'h5A, a1); wb(8'h02, a2); wb(8'h99, a3); bus_stop();
    chk("R2 mismatch NACK and silence", {61'd0, a1, a2, a3}, 64'd7);
    chk("R2 register untouched", {56'd0, regs[23:16]}, 64'h11);

    // chip select low (R7)
    cs = 1'b0; clks(5);
    wr_reg(7'h2C, 8'h03, 8'h77, ok);
    chk("R7 no response while deselected", {63'd0, ok}, 64'd0);
    cs = 1'b1; clks(5);
    chk("R7 register untouched", {56'd0, regs[31:24]}, 64'h22);
    bus_start(); wb(8'h58, a1); wb(8'h03, a2);
    cs = 1'b0; clks(5); cs = 1'b1; clks(5);
    wb(8'h66, a3); bus_stop();
    chk("R7 abort mid-transfer", {61'd0, a1, a2, a3}, 64'd1);
    chk("R7 aborted write discarded", {56'd0, regs[31:24]}, 64'h22);

    // bus held idle-high inside a byte (R8)
    bus_start(); wb(8'h58, a1);
    sda_h = 1'b1; clks(H);
    scl_h = 1'b1; clks(FREE + 20);
    scl_h = 1'b0; clks(H);
    send_bits(8'h08, 7, ack);
    bus_stop();
    chk("R8 timeout drops transfer", {62'd0, a1, ack}, 64'd1);
    wr_reg(7'h2C, 8'h06, 8'h5C, ok);
    chk("R8 next START accepted", {63'd0, ok}, 64'd1);

    // soft reset (R6)
    wr_reg(7'h2C, 8'h01, 8'h01, ok);
    chk("R6 soft reset restores defaults", regs, defaults(8'h58));
    rd_reg(7'h2C, 8'h01, d, ok);
    chk("R6 reset bit reads 0", {55'd0, ok, d}, 64'h100);

    // rewrite the slave address (R5)
    wr_reg(7'h2C, 8'h00, 8'h43, ok);
    chk("R5 address register bit0 low", {55'd0, ok, regs[7:0]}, 64'h142);
    rd_reg(7'h2C, 8'h00, d, ok);
    chk("R5 old address refused", {63'd0, ok}, 64'd0);
    rd_reg(7'h21, 8'h00, d, ok);
    chk("R5 new address answers", {55'd0, ok, d}, 64'h142);
    wr_reg(7'h21, 8'h02, 8'h11, ok);
    wr_reg(7'h21, 8'h01, 8'hFF, ok);
    chk("R6 soft reset keeps new address", regs, defaults(8'h42));

    // hard reset restores the address (R9)
    rst_n = 1'b0; clks(4);
    chk("R9 hard reset restores address", regs, defaults(8'h58));
    rst_n = 1'b1; clks(4);

    done = 1'b1;
    report();
    $finish;
  end
endmodule